// File: doc/BRIEF.md
# Packed Lane Shuffle Unit

This block rearranges the lanes of two 128-bit vectors under the control of an 8-bit immediate. The first vector always supplies the low half of the result and the second vector always supplies the high half. A single mode input sets the lane size, and the immediate is decoded differently for each size. With 32-bit lanes, the immediate holds four 2-bit selectors, one for each result doubleword. With 64-bit lanes, it holds two 1-bit quadword selectors, and the six upper bits must be zero. Lane contents are moved as raw bits and are never interpreted.

A request is given as both vectors, the immediate and the mode, qualified by `in_valid`. The result and a reserved-bit error flag are registered. They appear with `out_valid` one clock later. Every output lane is read from the input values as they were presented, so no lane depends on another lane's write. A two-state controller sequences the output. `IDLE` moves to `EMIT` on a valid request, through the transition named *accept*. `EMIT` stays in `EMIT` on a further request, through *stream*. `EMIT` returns to `IDLE` when no request arrives, through *drain*. `IDLE` stays in `IDLE` without a request, through *wait*.

Top module: `lane_permute_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_err` and `out_result` are all zero.
- R2: With `lane_mode`=0 (32-bit lanes), `imm[1:0]`=n places doubleword n of `vec_a` in result bits 31:0. `imm[3:2]`=n places doubleword n of `vec_a` in bits 63:32. Doubleword n is bits 32n+31:32n.
- R3: With `lane_mode`=0, `imm[5:4]`=n places doubleword n of `vec_b` in result bits 95:64. `imm[7:6]`=n places doubleword n of `vec_b` in bits 127:96.
- R4: With `lane_mode`=1 (64-bit lanes), `imm[0]` picks the quadword of `vec_a` for result bits 63:0. A value of 0 picks bits 63:0 and a value of 1 picks bits 127:64.
- R5: With `lane_mode`=1, `imm[1]` picks the quadword of `vec_b` for result bits 127:64, with the same 0/1 meaning as R4.
- R6: `out_err` is 1 when `lane_mode`=1 and any of `imm[7:2]` is set, and the result is still formed from `imm[1:0]`. With `lane_mode`=0, `out_err` is always 0.
- R7: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. Result and error for that request are presented in the same cycle.
- R8: A cycle with `in_valid` low gives `out_valid` low in the following cycle. In that case `out_result` and `out_err` keep their previous values, whatever the other inputs do.
- R9: The selectors are independent. One source lane may feed several result lanes, and requests given on back-to-back cycles each produce their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| lane_mode | input | 1 | 0 = 32-bit lanes, 1 = 64-bit lanes |
| imm | input | 8 | Lane selection immediate |
| vec_a | input | 128 | First operand, feeds the low half of the result |
| vec_b | input | 128 | Second operand, feeds the high half of the result |
| out_result | output | 128 | Registered shuffled vector |
| out_err | output | 1 | Reserved immediate bits were set in 64-bit mode |
| out_valid | output | 1 | Result and error are valid |

## Verification
The hardest case to reach from the ports is a 64-bit-mode request with reserved bits set. There, the error flag must rise while the data path still obeys the two low immediate bits. The stimulus table includes immediates that set a single reserved bit and all reserved bits, each paired with a distinct quadword choice, so a wrong decode shows up in the data. Every lane of both operands carries a unique pattern, so any misrouted doubleword is visible. The table is applied with the strobe held high throughout, which exercises the *stream* transition. Idle cycles with changed inputs then test the hold behaviour.

// File: rtl/lane_permute_pkg.sv
package lane_permute_pkg;
    localparam int NUM_LANES = 4;
    localparam int SEL_W     = $clog2(NUM_LANES);
    localparam int IMM_W     = NUM_LANES * SEL_W;
    localparam int HALF      = NUM_LANES / 2;

    typedef enum logic {
        MODE_DWORD = 1'b0,
        MODE_QWORD = 1'b1
    } lane_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } ctrl_state_e;

    typedef logic [SEL_W-1:0] lane_sel_t;
endpackage

// File: rtl/shuffle_imm_decoder.sv
module shuffle_imm_decoder
    import lane_permute_pkg::*;
(
    input  logic                  lane_mode,
    input  logic [IMM_W-1:0]      imm,
    output lane_sel_t             sel [NUM_LANES],
    output logic                  rsvd_err
);
    lane_mode_e mode;
    assign mode = lane_mode_e'(lane_mode);

    // Quadword mode: each half uses one immediate bit; result lane k in a
    // half takes source lane {bit, k%2}.
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_sel
        localparam int HALF_IDX = k / HALF;
        localparam int SUB      = k % HALF;
        always_comb begin
            unique case (mode)
                MODE_DWORD: sel[k] = imm[k*SEL_W +: SEL_W];
                MODE_QWORD: sel[k] = {imm[HALF_IDX], SUB[0]};
                default:    sel[k] = '0;
            endcase
        end
    end

    always_comb begin
        unique case (mode)
            MODE_QWORD: rsvd_err = |imm[IMM_W-1:2];
            default:    rsvd_err = 1'b0;
        endcase
    end
endmodule

// File: rtl/shuffle_crossbar.sv
module shuffle_crossbar
    import lane_permute_pkg::*;
#(
    parameter int LANE_W = 32,
    localparam int VEC_W = LANE_W * NUM_LANES
) (
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    input  lane_sel_t        sel [NUM_LANES],
    output logic [VEC_W-1:0] shuffled
);
    // Every lane reads the unmodified inputs; no lane sees another's output.
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        if (k < HALF) begin : g_from_a
            assign shuffled[k*LANE_W +: LANE_W] = vec_a[sel[k]*LANE_W +: LANE_W];
        end else begin : g_from_b
            assign shuffled[k*LANE_W +: LANE_W] = vec_b[sel[k]*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/shuffle_ctrl.sv
module shuffle_ctrl
    import lane_permute_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic load_en,
    output logic out_valid
);
    ctrl_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = in_valid ? ST_EMIT : ST_IDLE;   // accept / wait
            ST_EMIT: state_nx = in_valid ? ST_EMIT : ST_IDLE;   // stream / drain
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load_en   = in_valid;
        unique case (state)
            ST_EMIT: out_valid = 1'b1;
            default: out_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
    import lane_permute_pkg::*;
#(
    parameter int LANE_W = 32,
    localparam int VEC_W = LANE_W * NUM_LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             lane_mode,
    input  logic [IMM_W-1:0] imm,
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    output logic [VEC_W-1:0] out_result,
    output logic             out_err,
    output logic             out_valid
);
    lane_sel_t        sel [NUM_LANES];
    logic             rsvd_err;
    logic [VEC_W-1:0] shuffled;
    logic             load_en;

    shuffle_imm_decoder u_dec (
        .lane_mode (lane_mode),
        .imm       (imm),
        .sel       (sel),
        .rsvd_err  (rsvd_err)
    );

    shuffle_crossbar #(.LANE_W(LANE_W)) u_xbar (
        .vec_a    (vec_a),
        .vec_b    (vec_b),
        .sel      (sel),
        .shuffled (shuffled)
    );

    shuffle_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .load_en   (load_en),
        .out_valid (out_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_result <= '0;
            out_err    <= 1'b0;
        end else if (load_en) begin
            out_result <= shuffled;
            out_err    <= rsvd_err;
        end
    end
endmodule

// File: rtl/lane_permute_checker.sv
module lane_permute_checker
    import lane_permute_pkg::*;
#(
    parameter int LANE_W = 32,
    localparam int VEC_W = LANE_W * NUM_LANES,
    localparam int QW    = 2 * LANE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             lane_mode,
    input logic [IMM_W-1:0] imm,
    input logic [VEC_W-1:0] vec_a,
    input logic [VEC_W-1:0] vec_b,
    input logic [VEC_W-1:0] out_result,
    input logic             out_err,
    input logic             out_valid
);
    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_err)));

    assert_no_err_dword_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !lane_mode) |=> !out_err);

    assert_err_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode && (|imm[IMM_W-1:2])) |=> out_err);

    assert_low_quad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode) |=>
            out_result[QW-1:0] == ($past(imm[0]) ? $past(vec_a[VEC_W-1:QW]) : $past(vec_a[QW-1:0])));

    assert_high_quad_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mode) |=>
            out_result[VEC_W-1:QW] == ($past(imm[1]) ? $past(vec_b[VEC_W-1:QW]) : $past(vec_b[QW-1:0])));
endmodule

bind lane_permute_unit lane_permute_checker #(.LANE_W(LANE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .lane_mode  (lane_mode),
    .imm        (imm),
    .vec_a      (vec_a),
    .vec_b      (vec_b),
    .out_result (out_result),
    .out_err    (out_err),
    .out_valid  (out_valid)
);

// File: tb/test_lane_permute_unit.sv
module test_lane_permute_unit;
    localparam int N = 11;
    localparam logic [31:0] A0 = 32'hA0A0A0A0, A1 = 32'hA1A1A1A1,
                            A2 = 32'hA2A2A2A2, A3 = 32'hA3A3A3A3;
    localparam logic [31:0] B0 = 32'hB0B0B0B0, B1 = 32'hB1B1B1B1,
                            B2 = 32'hB2B2B2B2, B3 = 32'hB3B3B3B3;
    localparam logic [127:0] VA = {A3, A2, A1, A0};
    localparam logic [127:0] VB = {B3, B2, B1, B0};

    localparam logic       T_MODE [N] = '{0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 0};
    localparam logic [7:0] T_IMM  [N] = '{8'h00, 8'hE4, 8'h1B, 8'hFF, 8'h00, 8'h01,
                                          8'h02, 8'h03, 8'h04, 8'hFE, 8'h9C};
    localparam logic [127:0] T_EXP [N] = '{
        {B0, B0, A0, A0}, {B3, B2, A1, A0}, {B0, B1, A2, A3}, {B3, B3, A3, A3},
        {B1, B0, A1, A0}, {B1, B0, A3, A2}, {B3, B2, A1, A0}, {B3, B2, A3, A2},
        {B1, B0, A1, A0}, {B3, B2, A1, A0}, {B2, B1, A3, A0}};
    localparam logic       T_ERR  [N] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0};
    localparam string      T_REQ  [N] = '{"R2 R3 R9", "R2 R3", "R2 R3", "R9", "R4 R5",
                                          "R4", "R5", "R4 R5", "R6", "R6", "R2 R3"};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         lane_mode = 1'b0;
    logic [7:0]   imm = '0;
    logic [127:0] vec_a = VA;
    logic [127:0] vec_b = VB;
    logic [127:0] out_result;
    logic         out_err;
    logic         out_valid;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    lane_permute_unit i_lane_permute_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_mode(lane_mode),
        .imm(imm), .vec_a(vec_a), .vec_b(vec_b),
        .out_result(out_result), .out_err(out_err), .out_valid(out_valid)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 valid", {127'b0, out_valid}, 128'd0);
        check("R1 err", {127'b0, out_err}, 128'd0);
        check("R1 result", out_result, 128'd0);
        rst_n = 1'b1;

        // Table walk with the strobe held high (stream transition, R7, R9)
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            in_valid  = 1'b1;
            lane_mode = T_MODE[i];
            imm       = T_IMM[i];
            @(negedge clk);
            check({T_REQ[i], " R7 valid"}, {127'b0, out_valid}, 128'd1);
            check({T_REQ[i], " result"}, out_result, T_EXP[i]);
            check({T_REQ[i], " err"}, {127'b0, out_err}, {127'b0, T_ERR[i]});
        end

        // R8: idle cycles with changed inputs leave outputs alone
        in_valid  = 1'b0;
        lane_mode = 1'b1;
        imm       = 8'hFF;
        vec_a     = ~VA;
        vec_b     = ~VB;
        @(negedge clk);
        check("R8 valid low", {127'b0, out_valid}, 128'd0);
        @(negedge clk);
        check("R8 result held", out_result, T_EXP[N-1]);
        check("R8 err held", {127'b0, out_err}, 128'd0);

        // R6: all reserved bits, result still uses imm[1:0]=01
        in_valid = 1'b1;
        imm      = 8'hFD;
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 err", {127'b0, out_err}, 128'd1);
        check("R6 R4 R5 result", out_result, {~B1, ~B0, ~A3, ~A2});
        @(negedge clk);
        check("R8 err held", {127'b0, out_err}, 128'd1);

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 result after reset", out_result, 128'd0);
        check("R1 err after reset", {127'b0, out_err}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule